// File: doc/BRIEF.md
# Byte/Word Host Access Aligner

This block sits between a host bus that moves either single bytes or 16-bit words and a 16-bit internal frame buffer port. It carries one sequential write stream and one sequential read stream. On the write side it gathers a low byte and the high byte that follows into one little-endian buffer word. On the read side it fetches a whole word for a low-byte read and serves the high byte from a holding register on the next byte read. Word accesses pass straight through when the stream is at an even byte position.

Each direction has its own two-state machine. The write machine has the states `WR_EVEN`, where no byte is pending, and `WR_HELD`, where a low byte waits for its partner. The transitions are: a byte write moves `WR_EVEN` to `WR_HELD`, a byte write moves `WR_HELD` back to `WR_EVEN` and commits the word, a word write keeps `WR_EVEN`, a rejected word write keeps `WR_HELD`, and a restart goes to `WR_EVEN`. The read machine has the states `RD_EVEN` and `RD_HELD`, where a fetched high byte waits to be read. Its transitions are the same: a byte read goes `RD_EVEN`→`RD_HELD`, a byte read goes `RD_HELD`→`RD_EVEN`, a word read keeps `RD_EVEN`, a rejected word read keeps `RD_HELD`, and a restart goes to `RD_EVEN`.

A word access while its direction sits at an odd byte position would break the rule that internal words start on even byte addresses. Such an access is refused, and a sticky alignment-error flag is raised. All buffer-side strobes and host read data are combinational and appear in the same cycle as the host access.

Top module: `host_aligner`

## Requirements
- R1: After reset both lanes report even (`wr_lane_odd`=0, `rd_lane_odd`=0), `align_err` is 0 and no buffer strobe is active.
- R2: A word write (`host_word`=1) in `WR_EVEN` drives `buf_wr_en`=1 with `buf_wr_data` equal to `host_wdata` in the same cycle, and the write lane stays even.
- R3: A byte write in `WR_EVEN` takes `host_wdata[7:0]`, makes no buffer write, and sets `wr_lane_odd` to 1 after the clock edge.
- R4: A byte write in `WR_HELD` drives `buf_wr_en`=1 with `buf_wr_data` = {this byte in bits 15:8, held byte in bits 7:0}, and the write lane returns to even.
- R5: A word read in `RD_EVEN` drives `buf_rd_en`=1 and returns `buf_rd_data` unchanged on `host_rdata` in the same cycle.
- R6: A byte read in `RD_EVEN` drives `buf_rd_en`=1, returns `buf_rd_data[7:0]` in `host_rdata[7:0]` with bits 15:8 zero, and sets `rd_lane_odd` to 1.
- R7: A byte read in `RD_HELD` makes no buffer fetch and returns the high byte kept from the earlier fetch in `host_rdata[7:0]` (bits 15:8 zero), and the read lane returns to even.
- R8: A word access in either direction while that direction's lane is odd raises `host_reject`, makes no buffer strobe, leaves the lane and held byte unchanged, and sets `align_err`. `align_err` stays at 1 until restart or reset.
- R9: `stream_restart`=1 returns both lanes to even, drops the held bytes and clears `align_err`. Any host access in the same cycle is dropped, with no strobe and no reject.
- R10: The two directions are independent: write accesses never change `rd_lane_odd` and read accesses never change `wr_lane_odd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stream_restart | input | 1 | Synchronous restart of both streams |
| host_valid | input | 1 | Host access in this cycle |
| host_write | input | 1 | 1 = write, 0 = read |
| host_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| host_wdata | input | 16 | Write data; a byte uses bits 7:0 |
| host_rdata | output | 16 | Read data; a byte is returned in bits 7:0 |
| host_reject | output | 1 | Access refused for misalignment |
| buf_wr_en | output | 1 | Buffer word write strobe |
| buf_wr_data | output | 16 | Buffer word write data |
| buf_rd_en | output | 1 | Buffer word fetch strobe (advances the stream) |
| buf_rd_data | input | 16 | Current buffer word at the head of the read stream |
| wr_lane_odd | output | 1 | Write stream sits at an odd byte position |
| rd_lane_odd | output | 1 | Read stream sits at an odd byte position |
| align_err | output | 1 | Sticky alignment-error flag |

## Verification
The assertions assume that the host inputs are stable across each clock edge, and that `buf_rd_data` holds the head word of the read stream for the whole cycle in which `buf_rd_en` is sampled. They also assume that `stream_restart` is a clean single-cycle level with no unknown values. The bench changes every input only at the falling clock edge, and it samples the combinational strobes a short delay later. It samples the lane and flag outputs just after the rising edge. It also places a new buffer word before each fetch so that every returned byte has a known source.

// File: rtl/host_aligner_pkg.sv
package host_aligner_pkg;

    typedef enum logic {
        WR_EVEN = 1'b0,
        WR_HELD = 1'b1
    } wr_state_e;

    typedef enum logic {
        RD_EVEN = 1'b0,
        RD_HELD = 1'b1
    } rd_state_e;

endpackage

// File: rtl/wr_packer.sv
module wr_packer
    import host_aligner_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restart,
    input  logic                acc,
    input  logic                word,
    input  logic [2*BYTE_W-1:0] wdata,
    output logic                wr_en,
    output logic [2*BYTE_W-1:0] wr_data,
    output logic                reject,
    output logic                lane_odd
);
    localparam int WORD_W = 2 * BYTE_W;

    wr_state_e         state_q, state_d;
    logic [BYTE_W-1:0] held_q;
    logic              capture;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WR_EVEN;
            held_q  <= '0;
        end else if (restart) begin
            state_q <= WR_EVEN;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            if (capture) held_q <= wdata[BYTE_W-1:0];
        end
    end

    always_comb begin
        state_d = state_q;
        wr_en   = 1'b0;
        wr_data = '0;
        reject  = 1'b0;
        capture = 1'b0;
        if (acc && !restart) begin
            unique case (state_q)
                WR_EVEN: begin
                    if (word) begin
                        wr_en   = 1'b1;
                        wr_data = wdata;
                    end else begin
                        capture = 1'b1;
                        state_d = WR_HELD;
                    end
                end
                WR_HELD: begin
                    if (word) begin
                        reject = 1'b1;
                    end else begin
                        wr_en   = 1'b1;
                        wr_data = {wdata[BYTE_W-1:0], held_q};
                        state_d = WR_EVEN;
                    end
                end
                default: state_d = WR_EVEN;
            endcase
        end
    end

    assign lane_odd = (state_q == WR_HELD);

    logic unused_hi;
    assign unused_hi = ^wdata[WORD_W-1:BYTE_W];

endmodule

// File: rtl/rd_splitter.sv
module rd_splitter
    import host_aligner_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restart,
    input  logic                acc,
    input  logic                word,
    input  logic [2*BYTE_W-1:0] buf_data,
    output logic                rd_en,
    output logic [2*BYTE_W-1:0] rdata,
    output logic                reject,
    output logic                lane_odd
);
    localparam int WORD_W = 2 * BYTE_W;

    rd_state_e         state_q, state_d;
    logic [BYTE_W-1:0] held_q;
    logic              capture;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_EVEN;
            held_q  <= '0;
        end else if (restart) begin
            state_q <= RD_EVEN;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            if (capture) held_q <= buf_data[WORD_W-1:BYTE_W];
        end
    end

    always_comb begin
        state_d = state_q;
        rd_en   = 1'b0;
        rdata   = '0;
        reject  = 1'b0;
        capture = 1'b0;
        if (acc && !restart) begin
            unique case (state_q)
                RD_EVEN: begin
                    rd_en = 1'b1;
                    if (word) begin
                        rdata = buf_data;
                    end else begin
                        rdata   = {{BYTE_W{1'b0}}, buf_data[BYTE_W-1:0]};
                        capture = 1'b1;
                        state_d = RD_HELD;
                    end
                end
                RD_HELD: begin
                    if (word) begin
                        reject = 1'b1;
                    end else begin
                        rdata   = {{BYTE_W{1'b0}}, held_q};
                        state_d = RD_EVEN;
                    end
                end
                default: state_d = RD_EVEN;
            endcase
        end
    end

    assign lane_odd = (state_q == RD_HELD);

endmodule

// File: rtl/align_err_flag.sv
module align_err_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic set,
    output logic flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     flag <= 1'b0;
        else if (clear) flag <= 1'b0;
        else if (set)   flag <= 1'b1;
    end
endmodule

// File: rtl/host_aligner.sv
module host_aligner
    import host_aligner_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stream_restart,
    input  logic                host_valid,
    input  logic                host_write,
    input  logic                host_word,
    input  logic [2*BYTE_W-1:0] host_wdata,
    output logic [2*BYTE_W-1:0] host_rdata,
    output logic                host_reject,
    output logic                buf_wr_en,
    output logic [2*BYTE_W-1:0] buf_wr_data,
    output logic                buf_rd_en,
    input  logic [2*BYTE_W-1:0] buf_rd_data,
    output logic                wr_lane_odd,
    output logic                rd_lane_odd,
    output logic                align_err
);
    logic wr_acc, rd_acc, wr_rej, rd_rej;

    assign wr_acc = host_valid &&  host_write;
    assign rd_acc = host_valid && !host_write;

    wr_packer #(.BYTE_W(BYTE_W)) wr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (stream_restart),
        .acc      (wr_acc),
        .word     (host_word),
        .wdata    (host_wdata),
        .wr_en    (buf_wr_en),
        .wr_data  (buf_wr_data),
        .reject   (wr_rej),
        .lane_odd (wr_lane_odd)
    );

    rd_splitter #(.BYTE_W(BYTE_W)) rd_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (stream_restart),
        .acc      (rd_acc),
        .word     (host_word),
        .buf_data (buf_rd_data),
        .rd_en    (buf_rd_en),
        .rdata    (host_rdata),
        .reject   (rd_rej),
        .lane_odd (rd_lane_odd)
    );

    assign host_reject = wr_rej || rd_rej;

    align_err_flag err_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (stream_restart),
        .set   (host_reject),
        .flag  (align_err)
    );

endmodule

// File: rtl/host_aligner_chk.sv
module host_aligner_chk #(
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                stream_restart,
    input logic                host_valid,
    input logic                host_write,
    input logic                host_word,
    input logic [2*BYTE_W-1:0] host_wdata,
    input logic                host_reject,
    input logic                buf_wr_en,
    input logic [2*BYTE_W-1:0] buf_wr_data,
    input logic                buf_rd_en,
    input logic                wr_lane_odd,
    input logic                rd_lane_odd,
    input logic                align_err
);
    AST_WORD_WR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_write && host_word && !wr_lane_odd && !stream_restart)
        |-> (buf_wr_en && buf_wr_data == host_wdata)); // R2

    AST_BYTE_WR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_write && !host_word && !stream_restart)
        |=> (wr_lane_odd != $past(wr_lane_odd))); // R3

    AST_HELD_RD_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && !host_write && !host_word && rd_lane_odd && !stream_restart)
        |-> !buf_rd_en); // R7

    AST_REJECT_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        host_reject |-> (!buf_wr_en && !buf_rd_en)); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (align_err && !stream_restart) |=> align_err); // R8

    AST_RESTART_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        stream_restart |=> (!wr_lane_odd && !rd_lane_odd && !align_err)); // R9

    AST_RESTART_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        stream_restart |-> (!buf_wr_en && !buf_rd_en && !host_reject)); // R9

    AST_RD_LANE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_write && !stream_restart)
        |=> (rd_lane_odd == $past(rd_lane_odd))); // R10

    AST_WR_LANE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && !host_write && !stream_restart)
        |=> (wr_lane_odd == $past(wr_lane_odd))); // R10
endmodule

bind host_aligner host_aligner_chk #(.BYTE_W(BYTE_W)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .stream_restart (stream_restart),
    .host_valid     (host_valid),
    .host_write     (host_write),
    .host_word      (host_word),
    .host_wdata     (host_wdata),
    .host_reject    (host_reject),
    .buf_wr_en      (buf_wr_en),
    .buf_wr_data    (buf_wr_data),
    .buf_rd_en      (buf_rd_en),
    .wr_lane_odd    (wr_lane_odd),
    .rd_lane_odd    (rd_lane_odd),
    .align_err      (align_err)
);

// File: tb/host_aligner_tb_top.sv
`timescale 1ns/1ps
module host_aligner_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stream_restart = 1'b0;
    logic        host_valid = 1'b0;
    logic        host_write = 1'b0;
    logic        host_word = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_reject;
    logic        buf_wr_en;
    logic [15:0] buf_wr_data;
    logic        buf_rd_en;
    logic [15:0] buf_rd_data = '0;
    logic        wr_lane_odd, rd_lane_odd, align_err;

    int n_run = 0;
    int n_fail = 0;

    // Values captured during the last access
    logic        s_wr_en, s_rd_en, s_rej;
    logic [15:0] s_wr_data, s_rdata;

    always #4 clk = ~clk;

    host_aligner dut_i (
        .clk(clk), .rst_n(rst_n), .stream_restart(stream_restart),
        .host_valid(host_valid), .host_write(host_write), .host_word(host_word),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_reject(host_reject),
        .buf_wr_en(buf_wr_en), .buf_wr_data(buf_wr_data), .buf_rd_en(buf_rd_en),
        .buf_rd_data(buf_rd_data), .wr_lane_odd(wr_lane_odd),
        .rd_lane_odd(rd_lane_odd), .align_err(align_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic wd, input logic [15:0] d,
                          input logic rs = 1'b0);
        @(negedge clk);
        host_valid = 1'b1; host_write = wr; host_word = wd; host_wdata = d;
        stream_restart = rs;
        #1;
        s_wr_en = buf_wr_en; s_wr_data = buf_wr_data; s_rd_en = buf_rd_en;
        s_rdata = host_rdata; s_rej = host_reject;
        @(posedge clk); #1;
        host_valid = 1'b0; stream_restart = 1'b0;
    endtask

    task automatic t_reset;
        #1;
        check("R1 wr lane", wr_lane_odd, 0);
        check("R1 rd lane", rd_lane_odd, 0);
        check("R1 err", align_err, 0);
        check("R1 strobes", {buf_wr_en, buf_rd_en}, 0);
    endtask

    task automatic t_word_write;
        access(1, 1, 16'hA5C3);
        check("R2 wr_en", s_wr_en, 1);
        check("R2 data", s_wr_data, 16'hA5C3);
        check("R2 lane", wr_lane_odd, 0);
    endtask

    task automatic t_byte_pair_write;
        access(1, 0, 16'hFF34);
        check("R3 no write", s_wr_en, 0);
        check("R3 lane odd", wr_lane_odd, 1);
        access(1, 0, 16'h0012);
        check("R4 wr_en", s_wr_en, 1);
        check("R4 data", s_wr_data, 16'h1234);
        check("R4 lane even", wr_lane_odd, 0);
    endtask

    task automatic t_word_read;
        buf_rd_data = 16'h7E81;
        access(0, 1, 0);
        check("R5 rd_en", s_rd_en, 1);
        check("R5 data", s_rdata, 16'h7E81);
        check("R5 lane", rd_lane_odd, 0);
    endtask

    task automatic t_byte_reads;
        buf_rd_data = 16'hBEEF;
        access(0, 0, 0);
        check("R6 rd_en", s_rd_en, 1);
        check("R6 data", s_rdata, 16'h00EF);
        check("R6 lane odd", rd_lane_odd, 1);
        buf_rd_data = 16'h1111;
        access(0, 0, 0);
        check("R7 no fetch", s_rd_en, 0);
        check("R7 data", s_rdata, 16'h00BE);
        check("R7 lane even", rd_lane_odd, 0);
    endtask

    task automatic t_misaligned_write;
        access(1, 0, 16'h0055);
        access(1, 1, 16'h9999);
        check("R8 reject", s_rej, 1);
        check("R8 no write", s_wr_en, 0);
        check("R8 err", align_err, 1);
        check("R8 lane kept", wr_lane_odd, 1);
        access(1, 0, 16'h0066);
        check("R8 held kept", s_wr_data, 16'h6655);
        check("R8 sticky", align_err, 1);
    endtask

    task automatic t_misaligned_read;
        buf_rd_data = 16'hC0DE;
        access(0, 0, 0);
        buf_rd_data = 16'h2222;
        access(0, 1, 0);
        check("R8 rd reject", s_rej, 1);
        check("R8 no fetch", s_rd_en, 0);
        check("R8 rd lane kept", rd_lane_odd, 1);
        access(0, 0, 0);
        check("R8 rd held kept", s_rdata, 16'h00C0);
    endtask

    task automatic t_restart;
        access(1, 0, 16'h0001);
        buf_rd_data = 16'h3344;
        access(0, 0, 0);
        access(1, 1, 16'h0000);
        check("R9 setup err", align_err, 1);
        access(1, 1, 16'h4321, 1'b1);
        check("R9 dropped", {s_wr_en, s_rej}, 0);
        check("R9 wr lane", wr_lane_odd, 0);
        check("R9 rd lane", rd_lane_odd, 0);
        check("R9 err clear", align_err, 0);
        access(1, 1, 16'h4321);
        check("R9 word after", s_wr_data, 16'h4321);
    endtask

    task automatic t_independence;
        access(1, 0, 16'h0077);
        buf_rd_data = 16'h5A5A;
        access(0, 1, 0);
        check("R10 read ok", {s_rd_en, s_rej}, 2'b10);
        check("R10 wr lane", wr_lane_odd, 1);
        buf_rd_data = 16'h9988;
        access(0, 0, 0);
        access(1, 0, 16'h0088);
        check("R10 rd lane", rd_lane_odd, 1);
        check("R10 pair", s_wr_data, 16'h8877);
    endtask

    initial begin
        fork
            begin
                #2; t_reset;
                repeat (2) @(posedge clk);
                #1 rst_n = 1'b1;
                t_word_write;
                t_byte_pair_write;
                t_word_read;
                t_byte_reads;
                t_misaligned_write;
                access(1, 1, 0, 1'b1);
                t_misaligned_read;
                t_restart;
                t_independence;
            end
            begin
                repeat (5000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule